// File: doc/BRIEF.md
# DMA Channel Activation and Request Arbiter

This block decides which channel of a small multi-channel DMA controller may run next. Each channel has a set of configuration registers and its own enable bit. One shared activation bit gates every channel. Request lines from peripherals are registered. Among the channels that are both enabled and activated, a fixed-priority selector grants one channel at a time. The external transfer engine receives the grant, which carries the granted channel's current source, destination and byte count. The engine pulses a completion input when it has finished.

Software reaches all state through a flat register bus. The bus has a write strobe and a combinational read port. Through it, software sets the activation and enable bits, loads the current and reload copies of the source address, destination address and byte count, selects reload on completion, and reads a pending-request bit per channel and a shared arbitration-status word. Configuration of a channel is frozen while that channel is enabled or is being served. Completion can reload the current registers from the reload copies. The same clock edge that ends one grant can already grant the next winner.

Parameters: `NUM_CH` (1 to 7 channels), `ADDR_W`, `CNT_W` and `DATA_W`, with `ADDR_W` and `CNT_W` no wider than `DATA_W`.

Top module: `dma_act_arbiter`

## Requirements
- R1: After reset the activation bit, every channel enable, every mode bit, the status word and all address and count registers read 0, and `gnt_valid` is 0.
- R2: A channel can be granted only if three things hold at the arbitration edge: its request was seen at the previous edge, its enable (bit 0 of the control register at word 8+8c+1) is 1, and the activation bit (bit 0 of word 0) is 1. A request that goes high before edge k is seen at edge k, and the grant then rises at edge k+1.
- R3: When the arbiter is free and several channels are eligible, the lowest channel index wins.
- R4: A grant stays on the same channel until `xfer_done` is sampled high, even if a higher-priority channel becomes eligible in the meantime. A `xfer_done` pulse while nothing is granted has no effect.
- R5: Bit 1 of each channel's control register shows the request level that was sampled at the last edge, whatever the channel's enable is.
- R6: Word 1 shows one status bit per channel. Bit c is 1 from the edge that grants channel c until the edge that samples its completion. At most one bit is set at a time.
- R7: A channel's configuration words (all offsets except 1) ignore writes while the channel is enabled or is being served. Otherwise they take the written value.
- R8: When a transfer completes on a channel whose mode bit (bit 0 of word 8+8c+0) is 1, that channel's current source, destination and count are loaded from its reload copies. With the mode bit at 0 they stay unchanged.
- R9: Clearing a channel's enable, or clearing the activation bit, does not revoke a grant that is in progress. After that grant completes, the affected channels get no new grant.
- R10: At the edge that samples `xfer_done`, the arbiter chooses again. If any channel is eligible, the next grant is active from that same edge, with no idle cycle in between.
- R11: Channel c occupies words 8+8c to 8+8c+7. The offsets are: mode, control, current source, current destination, current count, reload source, reload destination, reload count. Values read back as written, zero-extended. Unmapped words read 0. While `gnt_valid` is 1, `gnt_src`, `gnt_dst` and `gnt_cnt` show the granted channel's current registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_req | input | NUM_CH | Level-sensitive peripheral request per channel |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register word address for reads and writes |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| xfer_done | input | 1 | One-cycle completion pulse from the transfer engine |
| gnt_valid | output | 1 | A channel currently holds the grant |
| gnt_chan | output | clog2(NUM_CH) | Index of the granted channel |
| gnt_src | output | ADDR_W | Current source address of the granted channel |
| gnt_dst | output | ADDR_W | Current destination address of the granted channel |
| gnt_cnt | output | CNT_W | Current byte count of the granted channel |

## Verification
Completion and the next grant can fall on the same edge. On that edge a reload of the finishing channel's registers and a fresh arbitration happen together. The bench provokes this by pulsing `xfer_done` while other channels are enabled and requesting, including a case where the finishing reload channel keeps requesting and wins again. On the cycle after the pulse it checks that the grant moved with no gap and that the new grant carries the reloaded values. A behavioural model, stepped every clock, predicts the grant, the granted registers and the read data, and judges every cycle of these overlaps.

// File: rtl/dmaa_pkg.sv
package dmaa_pkg;

    // Word address width of the register bus
    localparam int REG_AW = 6;

    // Word offset of the first channel block and its size in words
    localparam int CH_BASE  = 8;
    localparam int CH_WORDS = 8;

    localparam logic [REG_AW-1:0] ADR_ACT  = 6'd0;
    localparam logic [REG_AW-1:0] ADR_STAT = 6'd1;

    // Layout inside one channel block
    typedef enum logic [2:0] {
        FLD_MODE = 3'd0,
        FLD_CTRL = 3'd1,
        FLD_SRC  = 3'd2,
        FLD_DST  = 3'd3,
        FLD_CNT  = 3'd4,
        FLD_RSRC = 3'd5,
        FLD_RDST = 3'd6,
        FLD_RCNT = 3'd7
    } fld_e;

endpackage

// File: rtl/dmaa_prio_pick.sv
module dmaa_prio_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Lowest set index wins: scan downwards so the last hit is the lowest
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/dmaa_chan_regs.sv
module dmaa_chan_regs
    import dmaa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  fld_e              wr_fld,
    input  logic [DATA_W-1:0] wr_data,
    input  fld_e              rd_fld,
    input  logic              req_seen,
    input  logic              serving,
    input  logic              finish,
    output logic              en,
    output logic [ADDR_W-1:0] src,
    output logic [ADDR_W-1:0] dst,
    output logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic              en;
        logic              reload;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] rsrc;
        logic [ADDR_W-1:0] rdst;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  rcnt;
    } chan_t;

    chan_t r_q, r_d;
    logic  locked;

    always_comb begin
        r_d    = r_q;
        locked = r_q.en | serving;
        if (wr_en) begin
            if (wr_fld == FLD_CTRL) begin
                r_d.en = wr_data[0];
            end else if (!locked) begin
                case (wr_fld)
                    FLD_MODE: r_d.reload = wr_data[0];
                    FLD_SRC:  r_d.src    = wr_data[ADDR_W-1:0];
                    FLD_DST:  r_d.dst    = wr_data[ADDR_W-1:0];
                    FLD_CNT:  r_d.cnt    = wr_data[CNT_W-1:0];
                    FLD_RSRC: r_d.rsrc   = wr_data[ADDR_W-1:0];
                    FLD_RDST: r_d.rdst   = wr_data[ADDR_W-1:0];
                    FLD_RCNT: r_d.rcnt   = wr_data[CNT_W-1:0];
                    default:  ;
                endcase
            end
        end
        // Completion only happens while serving, so it never meets an accepted write
        if (finish && r_q.reload) begin
            r_d.src = r_q.rsrc;
            r_d.dst = r_q.rdst;
            r_d.cnt = r_q.rcnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (rd_fld)
            FLD_MODE: rd_data = DATA_W'(r_q.reload);
            FLD_CTRL: rd_data = DATA_W'({req_seen, r_q.en});
            FLD_SRC:  rd_data = DATA_W'(r_q.src);
            FLD_DST:  rd_data = DATA_W'(r_q.dst);
            FLD_CNT:  rd_data = DATA_W'(r_q.cnt);
            FLD_RSRC: rd_data = DATA_W'(r_q.rsrc);
            FLD_RDST: rd_data = DATA_W'(r_q.rdst);
            default:  rd_data = DATA_W'(r_q.rcnt);
        endcase
    end

    assign en  = r_q.en;
    assign src = r_q.src;
    assign dst = r_q.dst;
    assign cnt = r_q.cnt;

endmodule

// File: rtl/dmaa_arbiter.sv
module dmaa_arbiter #(
    parameter int NUM_CH = 4,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] elig,
    input  logic              done,
    output logic              busy,
    output logic [IDX_W-1:0]  owner,
    output logic [NUM_CH-1:0] finish,
    output logic [NUM_CH-1:0] status
);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] owner;
    } arb_t;

    arb_t             a_q, a_d;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    logic             release_now;

    dmaa_prio_pick #(
        .N     (NUM_CH),
        .IDX_W (IDX_W)
    ) u_pick (
        .req (elig),
        .any (pick_any),
        .idx (pick_idx)
    );

    always_comb begin
        a_d         = a_q;
        release_now = a_q.busy & done;
        // Free, or freed at this edge: choose again in the same cycle
        if (!a_q.busy || release_now) begin
            a_d.busy = pick_any;
            if (pick_any) a_d.owner = pick_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            status[i] = a_q.busy && (a_q.owner == IDX_W'(i));
            finish[i] = release_now && (a_q.owner == IDX_W'(i));
        end
    end

    assign busy  = a_q.busy;
    assign owner = a_q.owner;

endmodule

// File: rtl/dma_act_arbiter.sv
module dma_act_arbiter
    import dmaa_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_CH-1:0]                      chan_req,
    input  logic                                   bus_wr,
    input  logic [5:0]                             bus_addr,
    input  logic [DATA_W-1:0]                      bus_wdata,
    output logic [DATA_W-1:0]                      bus_rdata,
    input  logic                                   xfer_done,
    output logic                                   gnt_valid,
    output logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)-1:0] gnt_chan,
    output logic [ADDR_W-1:0]                      gnt_src,
    output logic [ADDR_W-1:0]                      gnt_dst,
    output logic [CNT_W-1:0]                       gnt_cnt
);

    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic              act;
        logic [NUM_CH-1:0] req;
    } top_t;

    top_t st_q, st_d;

    logic [NUM_CH-1:0]             ch_en;
    logic [NUM_CH-1:0][ADDR_W-1:0] ch_src;
    logic [NUM_CH-1:0][ADDR_W-1:0] ch_dst;
    logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_rd;
    logic [NUM_CH-1:0]             status;
    logic [NUM_CH-1:0]             finish;
    logic [NUM_CH-1:0]             elig;
    logic                          busy;
    logic [IDX_W-1:0]              owner;
    fld_e                          fld;
    int                            ch_num;
    logic                          act_now;
    logic [NUM_CH-1:0]             req_now;

    // Address decode: block number above the field bits, minus the global block
    assign fld    = fld_e'(bus_addr[2:0]);
    assign ch_num = int'(bus_addr[REG_AW-1:3]) - (CH_BASE / CH_WORDS);

    always_comb begin
        st_d     = st_q;
        st_d.req = chan_req;
        if (bus_wr && bus_addr == ADR_ACT) st_d.act = bus_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_now = st_q.act;
    assign req_now = st_q.req;
    assign elig    = st_q.req & ch_en & {NUM_CH{st_q.act}};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dmaa_chan_regs #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W),
            .DATA_W (DATA_W)
        ) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bus_wr && ch_num == c),
            .wr_fld   (fld),
            .wr_data  (bus_wdata),
            .rd_fld   (fld),
            .req_seen (st_q.req[c]),
            .serving  (status[c]),
            .finish   (finish[c]),
            .en       (ch_en[c]),
            .src      (ch_src[c]),
            .dst      (ch_dst[c]),
            .cnt      (ch_cnt[c]),
            .rd_data  (ch_rd[c])
        );
    end

    dmaa_arbiter #(
        .NUM_CH (NUM_CH),
        .IDX_W  (IDX_W)
    ) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .elig   (elig),
        .done   (xfer_done),
        .busy   (busy),
        .owner  (owner),
        .finish (finish),
        .status (status)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADR_ACT) begin
            bus_rdata = DATA_W'(st_q.act);
        end else if (bus_addr == ADR_STAT) begin
            bus_rdata = DATA_W'(status);
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (ch_num == c) bus_rdata = ch_rd[c];
            end
        end
    end

    always_comb begin
        gnt_src = '0;
        gnt_dst = '0;
        gnt_cnt = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (status[c]) begin
                gnt_src = ch_src[c];
                gnt_dst = ch_dst[c];
                gnt_cnt = ch_cnt[c];
            end
        end
    end

    assign gnt_valid = busy;
    assign gnt_chan  = owner;

endmodule

// File: rtl/dmaa_checker.sv
module dmaa_checker #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int IDX_W  = 2
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             gnt_valid,
    input logic [IDX_W-1:0]                 gnt_chan,
    input logic                             xfer_done,
    input logic                             act,
    input logic [NUM_CH-1:0]                req,
    input logic [NUM_CH-1:0]                en,
    input logic [NUM_CH-1:0][ADDR_W-1:0]    src,
    input logic [NUM_CH-1:0][ADDR_W-1:0]    dst,
    input logic [NUM_CH-1:0][CNT_W-1:0]     cnt
);

    logic [NUM_CH-1:0] ok_now;
    logic [NUM_CH-1:0] ok_prev;
    logic [NUM_CH-1:0] low_mask;
    logic              was_valid;
    logic              was_done;
    logic              new_grant;

    assign ok_now   = req & en & {NUM_CH{act}};
    assign low_mask = (NUM_CH'(1) << gnt_chan) - NUM_CH'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_prev   <= '0;
            was_valid <= 1'b0;
            was_done  <= 1'b0;
        end else begin
            ok_prev   <= ok_now;
            was_valid <= gnt_valid;
            was_done  <= xfer_done;
        end
    end

    assign new_grant = gnt_valid && (!was_valid || was_done);

    assert_grant_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !xfer_done) |=> (gnt_valid && gnt_chan == $past(gnt_chan)));

    assert_grant_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        new_grant |-> ok_prev[gnt_chan]);

    assert_fixed_prio_R3: assert property (@(posedge clk) disable iff (!rst_n)
        new_grant |-> ((ok_prev & low_mask) == '0));

    assert_handover_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && xfer_done && (|ok_now)) |=> gnt_valid);

    assert_no_grant_inactive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && !gnt_valid) |=> !gnt_valid);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lock
        assert_cfg_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (en[c] && !(gnt_valid && gnt_chan == IDX_W'(c)))
            |=> ($stable(src[c]) && $stable(dst[c]) && $stable(cnt[c])));
    end

endmodule

bind dma_act_arbiter dmaa_checker #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt_valid (gnt_valid),
    .gnt_chan  (gnt_chan),
    .xfer_done (xfer_done),
    .act       (act_now),
    .req       (req_now),
    .en        (ch_en),
    .src       (ch_src),
    .dst       (ch_dst),
    .cnt       (ch_cnt)
);

// File: tb/test_dma_act_arbiter.sv
module test_dma_act_arbiter;

    localparam int N  = 4;
    localparam int AW = 32;
    localparam int CW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  chan_req = '0;
    logic          bus_wr = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          xfer_done = 1'b0;
    logic          gnt_valid;
    logic [1:0]    gnt_chan;
    logic [AW-1:0] gnt_src;
    logic [AW-1:0] gnt_dst;
    logic [CW-1:0] gnt_cnt;

    always #4 clk = ~clk;

    dma_act_arbiter #(.NUM_CH(N), .ADDR_W(AW), .CNT_W(CW), .DATA_W(DW)) i_dma_act_arbiter (
        .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .xfer_done(xfer_done), .gnt_valid(gnt_valid), .gnt_chan(gnt_chan),
        .gnt_src(gnt_src), .gnt_dst(gnt_dst), .gnt_cnt(gnt_cnt)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // Behavioural reference model
    bit          m_act;
    bit          m_en  [N];
    bit          m_rl  [N];
    bit          m_req [N];
    bit          m_busy;
    int          m_own;
    logic [31:0] m_src [N];
    logic [31:0] m_dst [N];
    logic [31:0] m_rsrc[N];
    logic [31:0] m_rdst[N];
    logic [15:0] m_cnt [N];
    logic [15:0] m_rcnt[N];

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] m_read(int a);
        logic [31:0] s;
        int c;
        s = '0;
        if (a == 0) return {31'b0, m_act};
        if (a == 1) begin
            if (m_busy) s[m_own] = 1'b1;
            return s;
        end
        if (a >= 8 && a < 8 + 8 * N) begin
            c = (a - 8) / 8;
            case (a % 8)
                0: return {31'b0, m_rl[c]};
                1: return {30'b0, m_req[c], m_en[c]};
                2: return m_src[c];
                3: return m_dst[c];
                4: return {16'b0, m_cnt[c]};
                5: return m_rsrc[c];
                6: return m_rdst[c];
                default: return {16'b0, m_rcnt[c]};
            endcase
        end
        return '0;
    endfunction

    always @(posedge clk) begin : mdl
        bit p_busy;
        int p_own;
        bit p_en [N];
        int a;
        int c;
        int f;
        bit lk;
        if (!rst_n) begin
            m_act  = 1'b0;
            m_busy = 1'b0;
            m_own  = 0;
            for (int i = 0; i < N; i++) begin
                m_en[i] = 0; m_rl[i] = 0; m_req[i] = 0;
                m_src[i] = '0; m_dst[i] = '0; m_rsrc[i] = '0; m_rdst[i] = '0;
                m_cnt[i] = '0; m_rcnt[i] = '0;
            end
        end else begin
            p_busy = m_busy;
            p_own  = m_own;
            p_en   = m_en;
            if (p_busy && xfer_done) begin
                if (m_rl[p_own]) begin
                    m_src[p_own] = m_rsrc[p_own];
                    m_dst[p_own] = m_rdst[p_own];
                    m_cnt[p_own] = m_rcnt[p_own];
                end
                m_busy = 1'b0;
            end
            if (!m_busy) begin
                for (int i = N - 1; i >= 0; i--) begin
                    if (m_req[i] && p_en[i] && m_act) begin
                        m_busy = 1'b1;
                        m_own  = i;
                    end
                end
            end
            if (bus_wr) begin
                a = int'(bus_addr);
                if (a == 0) begin
                    m_act = bus_wdata[0];
                end else if (a >= 8 && a < 8 + 8 * N) begin
                    c  = (a - 8) / 8;
                    f  = a % 8;
                    lk = p_en[c] || (p_busy && p_own == c);
                    if (f == 1) m_en[c] = bus_wdata[0];
                    else if (!lk) begin
                        case (f)
                            0: m_rl[c]   = bus_wdata[0];
                            2: m_src[c]  = bus_wdata;
                            3: m_dst[c]  = bus_wdata;
                            4: m_cnt[c]  = bus_wdata[15:0];
                            5: m_rsrc[c] = bus_wdata;
                            6: m_rdst[c] = bus_wdata;
                            default: m_rcnt[c] = bus_wdata[15:0];
                        endcase
                    end
                end
            end
            for (int i = 0; i < N; i++) m_req[i] = chan_req[i];
        end
    end

    // Cycle-by-cycle comparison, mid high phase
    always @(posedge clk) begin
        #2;
        if (rst_n && !finished) begin
            chk("R4 grant valid vs model", 32'(gnt_valid), 32'(m_busy));
            if (m_busy) begin
                chk("R3 grant channel vs model", 32'(gnt_chan), 32'(m_own));
                chk("R11 grant src vs model", gnt_src, m_src[m_own]);
                chk("R11 grant dst vs model", gnt_dst, m_dst[m_own]);
                chk("R11 grant cnt vs model", 32'(gnt_cnt), 32'(m_cnt[m_own]));
            end
            chk("R11 read data vs model", bus_rdata, m_read(int'(bus_addr)));
        end
    end

    task automatic finish_sim();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d cycles expected below 20000", cycles);
            finish_sim();
        end
    end

    function automatic int ra(int c, int f);
        return 8 + 8 * c + f;
    endfunction

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_addr = 6'(a);
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic pulse_done();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(0, 32'h0, "R1 activation after reset");
        rd(1, 32'h0, "R1 status after reset");
        rd(ra(2, 2), 32'h0, "R1 src after reset");
        rd(ra(3, 1), 32'h0, "R1 control after reset");
        chk("R1 no grant after reset", 32'(gnt_valid), 32'h0);

        // R11: configuration and readback
        for (int c = 0; c < N; c++) begin
            wr(ra(c, 2), 32'h1000 + c);
            wr(ra(c, 3), 32'h2000 + c);
            wr(ra(c, 4), 32'h10 + c);
            wr(ra(c, 5), 32'hA000 + c);
            wr(ra(c, 6), 32'hB000 + c);
            wr(ra(c, 7), 32'h40 + c);
        end
        wr(ra(1, 0), 32'h1);
        rd(ra(2, 2), 32'h1002, "R11 src readback");
        rd(ra(3, 7), 32'h43, "R11 reload count readback");
        rd(ra(1, 0), 32'h1, "R11 mode readback");
        rd(5, 32'h0, "R11 unmapped word");

        // R2/R5: request without enable
        @(negedge clk); chan_req[2] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 no grant without enable", 32'(gnt_valid), 32'h0);
        rd(ra(2, 1), 32'h2, "R5 pending bit while disabled");

        // R2: enabled but not activated
        wr(ra(2, 1), 32'h1);
        repeat (3) @(negedge clk);
        chk("R2 no grant without activation", 32'(gnt_valid), 32'h0);

        wr(0, 32'h1);
        @(negedge clk);
        chk("R2 grant after activation", 32'(gnt_valid), 32'h1);
        chk("R2 granted channel", 32'(gnt_chan), 32'h2);
        chk("R11 granted src", gnt_src, 32'h1002);
        rd(1, 32'h4, "R6 status bit set");

        // R4: no preemption by higher priority
        @(negedge clk); chan_req[0] = 1'b1;
        wr(ra(0, 1), 32'h1);
        repeat (3) @(negedge clk);
        chk("R4 grant held against higher priority", 32'(gnt_chan), 32'h2);

        // R7: lock while enabled, writable while disabled
        wr(ra(2, 2), 32'hDEAD);
        rd(ra(2, 2), 32'h1002, "R7 write ignored while enabled");
        wr(ra(3, 2), 32'h3333);
        rd(ra(3, 2), 32'h3333, "R7 write accepted while disabled");

        // R10: handover in the completion cycle
        @(negedge clk); chan_req[1] = 1'b1;
        wr(ra(1, 1), 32'h1);
        pulse_done();
        chk("R10 grant continues without gap", 32'(gnt_valid), 32'h1);
        chk("R10 handover to channel 0", 32'(gnt_chan), 32'h0);
        rd(1, 32'h1, "R6 status moved to channel 0");

        // R9: disable during transfer keeps the grant
        wr(ra(0, 1), 32'h0);
        repeat (2) @(negedge clk);
        chk("R9 grant kept after disable", 32'(gnt_valid), 32'h1);
        chk("R9 grant still channel 0", 32'(gnt_chan), 32'h0);
        wr(ra(0, 2), 32'h5555);
        rd(ra(0, 2), 32'h1000, "R7 write ignored while served");

        // R3: channels 1 and 2 eligible, 1 wins
        pulse_done();
        chk("R3 lowest eligible index wins", 32'(gnt_chan), 32'h1);

        // R8: reload on completion, same channel re-granted
        pulse_done();
        chk("R10 reload channel granted again", 32'(gnt_chan), 32'h1);
        chk("R8 granted src reloaded", gnt_src, 32'hA001);
        rd(ra(1, 4), 32'h41, "R8 count reloaded");
        rd(ra(1, 3), 32'hB001, "R8 dst reloaded");

        @(negedge clk); chan_req[1] = 1'b0;
        @(negedge clk);
        pulse_done();
        chk("R3 channel 2 after 1 drops", 32'(gnt_chan), 32'h2);

        // R9: deactivation keeps the running grant, blocks the next
        wr(0, 32'h0);
        repeat (2) @(negedge clk);
        chk("R9 grant kept after deactivation", 32'(gnt_valid), 32'h1);
        pulse_done();
        chk("R9 no new grant while inactive", 32'(gnt_valid), 32'h0);
        rd(ra(2, 2), 32'h1002, "R8 no reload with mode 0");
        rd(1, 32'h0, "R6 status cleared on completion");

        // R4: completion while idle ignored
        pulse_done();
        chk("R4 idle done gives no grant", 32'(gnt_valid), 32'h0);
        rd(ra(1, 2), 32'hA001, "R4 idle done leaves registers");

        // R2: reactivation
        wr(0, 32'h1);
        @(negedge clk);
        chk("R2 grant after reactivation", 32'(gnt_chan), 32'h2);
        rd(ra(0, 1), 32'h2, "R5 pending bit on disabled channel 0");

        repeat (4) @(negedge clk);
        finish_sim();
    end

endmodule